// File: doc/BRIEF.md
# Multi-Ramp Code Sequencer with Inter-Ramp Offset Calibration

This block produces the digital input codes for eight ramp DACs that feed a column-parallel multi-ramp converter. Each ramp has its own 12-bit start code and its own per-clock increment of 1, 2 or 4 LSB. Both are written through a small write port. A load pulse sets every ramp code to its start code. Each cycle with the step input high then advances every code by its increment, and a code stops at full scale. With equal increments all ramps share one slope. With increments in ratio 1:2:4, and each ramp's increment fixed for the whole conversion, the block gives the binary-scaled slopes that a companding transfer curve needs.

A calibration pass removes the offsets between ramps one pair at a time. For pair k, the block puts out a test level at the middle of ramp k's span and names ramp k on `cal_ramp`. A dedicated test column converts that level and returns its fine result. The block collects 2^N of these results and forms the average error against the ideal mid-span count. It then rounds that average and subtracts it from the start code of ramp k+1, clamping the result to the 12-bit range. The pass walks from pair 0 to pair 6 and then raises `cal_done`.

Top module: `mramp_codegen`

## Requirements
- R1: After reset every ramp code and every start code is 0, every increment is 1 LSB, `cal_busy` and `cal_done` are 0, and `cal_ramp` is 0.
- R2: A write with `cfg_addr[3]`=0 sets the start code of ramp `cfg_addr[2:0]` to `cfg_wdata`. A write with `cfg_addr[3]`=1 sets that ramp's increment from `cfg_wdata[1:0]`: 0 gives 1 LSB, 1 gives 2 LSB, 2 or 3 gives 4 LSB.
- R3: One cycle after `ramp_load`, each ramp code equals its start code. The load takes priority over `ramp_step` in the same cycle.
- R4: Each cycle with `ramp_step` high and no load adds the ramp's increment to its code. The code saturates at 4095.
- R5: One cycle after `cal_start`, `cal_busy` is 1, `cal_done` is 0 and `cal_ramp` is 0. While busy, `cal_level` equals min(start[k] + 64·inc[k], 4095), where k is `cal_ramp`.
- R6: Each `tst_valid` sample while busy contributes the error `tst_fine` − 64. After 2^N samples the average is rounded half up: floor((sum + 2^(N−1)) / 2^N), or the plain sum when N=0. Start[k+1] then becomes clamp(start[k+1] − average, 0, 4095), written at the edge of the last sample.
- R7: The pass steps k from 0 to 6, one step per finished correction. After the correction for k=6, `cal_busy` falls and `cal_done` rises in the same edge, and `cal_done` holds until the next `cal_start`.
- R8: `tst_valid` has no effect while `cal_busy` is 0.
- R9: N is taken from `cal_shift` at `cal_start`. Values above 6 act as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Bit 3 selects increment (1) or start code (0); bits 2:0 select the ramp |
| cfg_wdata | input | 12 | Write data |
| ramp_load | input | 1 | Set every code to its start code |
| ramp_step | input | 1 | Advance every code by its increment |
| ramp_code | output | 96 | Ramp i code in bits 12i+11:12i |
| cal_start | input | 1 | Begin a calibration pass |
| cal_shift | input | 3 | log2 of the samples averaged per pair |
| tst_valid | input | 1 | Test-column fine result valid |
| tst_fine | input | 8 | Test-column fine result |
| cal_ramp | output | 3 | Ramp whose mid-span is under test |
| cal_level | output | 12 | Test level code |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration pass finished |

## Verification
Loads, steps and configuration writes all land on the clock edge that samples them. The bench therefore drives on the falling edge and reads `ramp_code` at the next falling edge. A correction is written on the edge that takes the last averaged sample. In that same edge `cal_ramp` moves on, and on the final pair `cal_done` rises. `cal_level` follows the corrected start code at once, so the bench checks it right after that edge. The start codes themselves are read back one cycle after a later `ramp_load`.

// File: rtl/mramp_codegen.sv
module mramp_codegen #(
  parameter int NRAMP     = 8,
  parameter int CW        = 12,
  parameter int FW        = 8,
  parameter int FINE_MID  = 64,
  parameter int MAX_SHIFT = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [$clog2(NRAMP):0]         cfg_addr,
  input  logic [CW-1:0]                  cfg_wdata,
  input  logic                           ramp_load,
  input  logic                           ramp_step,
  output logic [NRAMP*CW-1:0]            ramp_code,
  input  logic                           cal_start,
  input  logic [$clog2(MAX_SHIFT+1)-1:0] cal_shift,
  input  logic                           tst_valid,
  input  logic [FW-1:0]                  tst_fine,
  output logic [$clog2(NRAMP)-1:0]       cal_ramp,
  output logic [CW-1:0]                  cal_level,
  output logic                           cal_busy,
  output logic                           cal_done
);
  localparam int IW   = $clog2(NRAMP);
  localparam int SHW  = $clog2(MAX_SHIFT+1);
  localparam int CNTW = MAX_SHIFT + 1;
  localparam int SUMW = FW + MAX_SHIFT + 2;
  localparam int LW   = CW + FW + 3;
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic [CW-1:0]  start_q [NRAMP];
  logic [CW-1:0]  code_q  [NRAMP];
  logic [1:0]     sel_q   [NRAMP];
  logic [2:0]     inc_w   [NRAMP];
  logic [IW-1:0]  k_q, nk;
  logic [SHW-1:0] sh_q;
  logic [CNTW-1:0] cnt_q, cnt_last;
  logic signed [SUMW-1:0] acc_q, err, sum_nxt, half, avg;
  logic signed [SUMW:0]   cval;
  logic [CW-1:0]  corr_val;
  logic [LW-1:0]  lvl_w;
  logic           take, fire, last_pair;

  assign nk        = k_q + 1'b1;
  assign take      = cal_busy && tst_valid;
  assign cnt_last  = ({{(CNTW-1){1'b0}}, 1'b1} << sh_q) - 1'b1;
  assign fire      = take && (cnt_q == cnt_last);
  assign last_pair = (k_q == IW'(NRAMP-2));

  assign err     = $signed({{(SUMW-FW){1'b0}}, tst_fine}) - SUMW'(FINE_MID);
  assign sum_nxt = acc_q + err;
  assign half    = $signed(({{(SUMW-1){1'b0}}, 1'b1} << sh_q) >> 1);
  assign avg     = (sum_nxt + half) >>> sh_q;
  assign cval    = $signed({{(SUMW+1-CW){1'b0}}, start_q[nk]}) - {avg[SUMW-1], avg};
  assign corr_val = cval[SUMW] ? '0 : (|cval[SUMW-1:CW] ? FULL : cval[CW-1:0]);

  assign lvl_w     = LW'(start_q[k_q]) + LW'(FINE_MID) * LW'(inc_w[k_q]);
  assign cal_level = |lvl_w[LW-1:CW] ? FULL : lvl_w[CW-1:0];
  assign cal_ramp  = k_q;

  for (genvar i = 0; i < NRAMP; i++) begin : g_ramp
    logic [CW:0] stepped;
    assign inc_w[i]  = (sel_q[i] == 2'd0) ? 3'd1 : (sel_q[i] == 2'd1) ? 3'd2 : 3'd4;
    assign stepped   = {1'b0, code_q[i]} + (CW+1)'(inc_w[i]);
    assign ramp_code[i*CW +: CW] = code_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[i] <= '0;
        sel_q[i]   <= '0;
        code_q[i]  <= '0;
      end else begin
        if (cfg_we && !cfg_addr[IW] && cfg_addr[IW-1:0] == IW'(i))
          start_q[i] <= cfg_wdata;
        else if (fire && nk == IW'(i))
          start_q[i] <= corr_val;
        if (cfg_we && cfg_addr[IW] && cfg_addr[IW-1:0] == IW'(i))
          sel_q[i] <= cfg_wdata[1:0];
        if (ramp_load)
          code_q[i] <= start_q[i];
        else if (ramp_step)
          code_q[i] <= stepped[CW] ? FULL : stepped[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_busy <= 1'b0;
      cal_done <= 1'b0;
      k_q      <= '0;
      sh_q     <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
    end else if (cal_start) begin
      cal_busy <= 1'b1;
      cal_done <= 1'b0;
      k_q      <= '0;
      sh_q     <= (cal_shift > SHW'(MAX_SHIFT)) ? SHW'(MAX_SHIFT) : cal_shift;
      cnt_q    <= '0;
      acc_q    <= '0;
    end else if (fire) begin
      cnt_q <= '0;
      acc_q <= '0;
      if (last_pair) begin
        cal_busy <= 1'b0;
        cal_done <= 1'b1;
      end else begin
        k_q <= nk;
      end
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= sum_nxt;
    end
  end

  // R7
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_busy && cal_done));

  // R5
  cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (cal_busy && !cal_done && cal_ramp == '0));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_load |=> (ramp_code[CW-1:0] == $past(start_q[0])));

  // R4
  step_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_step && !ramp_load) |=> (ramp_code[CW-1:0] >= $past(ramp_code[CW-1:0])));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && !cal_start) |=> ($stable(cal_ramp) && $stable(cal_busy)));

  // R9
  shift_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_q <= SHW'(MAX_SHIFT));
endmodule

// File: tb/tb_mramp_codegen.sv
module tb_mramp_codegen;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, ramp_load = 0, ramp_step = 0, cal_start = 0, tst_valid = 0;
  logic [3:0] cfg_addr = 0;
  logic [11:0] cfg_wdata = 0;
  logic [2:0] cal_shift = 0;
  logic [7:0] tst_fine = 0;
  logic [95:0] ramp_code;
  logic [2:0] cal_ramp;
  logic [11:0] cal_level;
  logic cal_busy, cal_done;

  int st[8], inc[8], cd[8];
  int tests = 0, fails = 0;

  mramp_codegen dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ramp_load(ramp_load), .ramp_step(ramp_step),
    .ramp_code(ramp_code), .cal_start(cal_start), .cal_shift(cal_shift),
    .tst_valid(tst_valid), .tst_fine(tst_fine), .cal_ramp(cal_ramp),
    .cal_level(cal_level), .cal_busy(cal_busy), .cal_done(cal_done));

  always #2 clk = ~clk;

  initial begin
    #(4*150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampc(int v);
    return v < 0 ? 0 : (v > 4095 ? 4095 : v);
  endfunction

  function automatic int sel2inc(int s);
    return s == 0 ? 1 : (s == 1 ? 2 : 4);
  endfunction

  function automatic int rnd_avg(int sum, int n);
    int d, t, q;
    if (n == 0) return sum;
    d = 1 << n;
    t = sum + d / 2;
    q = t / d;
    if (t < 0 && (t % d) != 0) q = q - 1;
    return q;
  endfunction

  task automatic wr_start(int r, int v);
    cfg_we = 1; cfg_addr = 4'(r); cfg_wdata = 12'(v); tick(); cfg_we = 0;
    st[r] = v;
  endtask

  task automatic wr_sel(int r, int s);
    cfg_we = 1; cfg_addr = 4'(8 + r); cfg_wdata = 12'(s); tick(); cfg_we = 0;
    inc[r] = sel2inc(s);
  endtask

  task automatic chk_codes(string req);
    for (int i = 0; i < 8; i++)
      chk(ramp_code[i*12 +: 12] == 12'(cd[i]), req, int'(ramp_code[i*12 +: 12]), cd[i]);
  endtask

  task automatic do_load(string req);
    ramp_load = 1; tick(); ramp_load = 0;
    for (int i = 0; i < 8; i++) cd[i] = st[i];
    chk_codes(req);
  endtask

  task automatic do_steps(int m);
    ramp_step = 1;
    for (int j = 0; j < m; j++) begin
      tick();
      for (int i = 0; i < 8; i++) cd[i] = clampc(cd[i] + inc[i]);
    end
    ramp_step = 0;
    chk_codes("R4");
  endtask

  function automatic int fine_of(int mode, int k);
    if (mode == 1) return (k == 0) ? 255 : ((k == 1) ? 0 : 64);
    return 44 + int'($urandom % 41);
  endfunction

  task automatic do_cal(int shin, int mode);
    int n, sum, f;
    n = shin > 6 ? 6 : shin;
    cal_shift = 3'(shin); cal_start = 1; tick(); cal_start = 0;
    chk(cal_busy && !cal_done && cal_ramp == 0, "R5", {cal_busy, cal_done}, 2);
    for (int k = 0; k < 7; k++) begin
      chk(cal_ramp == 3'(k), "R7", cal_ramp, k);
      chk(cal_level == 12'(clampc(st[k] + 64 * inc[k])), "R5", cal_level,
          clampc(st[k] + 64 * inc[k]));
      sum = 0;
      for (int j = 0; j < (1 << n); j++) begin
        f = fine_of(mode, k);
        sum += f - 64;
        tst_valid = 1; tst_fine = 8'(f); tick(); tst_valid = 0;
        if (j != (1 << n) - 1 && ($urandom % 2) == 1) tick();
      end
      st[k+1] = clampc(st[k+1] - rnd_avg(sum, n));
    end
    chk(!cal_busy && cal_done, "R7", {cal_busy, cal_done}, 1);
    tick();
    chk(cal_done == 1, "R7", cal_done, 1);
    do_load("R6");
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin st[i] = 0; inc[i] = 1; cd[i] = 0; end
    tick(); tick();
    chk_codes("R1");
    chk(!cal_busy && !cal_done && cal_ramp == 0, "R1", {cal_busy, cal_done}, 0);
    rst_n = 1; tick();
    do_load("R1");

    for (int i = 0; i < 8; i++) wr_start(i, 100 * i + 7);
    wr_sel(0, 0); wr_sel(1, 1); wr_sel(2, 2); wr_sel(3, 3);
    do_load("R2");
    do_steps(5);
    chk(ramp_code[3*12 +: 12] == 12'(307 + 20), "R2", int'(ramp_code[3*12 +: 12]), 327);

    ramp_load = 1; ramp_step = 1; tick(); ramp_load = 0; ramp_step = 0;
    for (int i = 0; i < 8; i++) cd[i] = st[i];
    chk_codes("R3");

    wr_start(5, 4090); wr_sel(5, 2);
    do_load("R3");
    do_steps(3);
    chk(ramp_code[5*12 +: 12] == 12'd4095, "R4", int'(ramp_code[5*12 +: 12]), 4095);

    for (int r = 0; r < 15; r++) begin
      for (int i = 0; i < 8; i++) begin
        wr_start(i, int'($urandom % 4096));
        wr_sel(i, int'($urandom % 4));
      end
      do_load("R3");
      do_steps(int'($urandom % 40) + 1);
    end

    for (int i = 0; i < 8; i++) begin wr_start(i, 512 * i + 20); wr_sel(i, 0); end
    tst_valid = 1; tst_fine = 8'd200; tick(); tick(); tst_valid = 0;
    do_load("R8");
    chk(!cal_busy && cal_ramp == 0, "R8", cal_ramp, 0);

    do_cal(0, 0);
    do_cal(2, 0);
    do_cal(7, 0);

    for (int i = 0; i < 8; i++) wr_sel(i, int'($urandom % 4));
    do_cal(3, 0);

    wr_start(0, 4000); wr_sel(0, 2);
    wr_start(1, 2); wr_start(2, 4090); wr_sel(1, 0);
    do_cal(0, 1);
    chk(st[1] == 0 && st[2] == 4095, "R6", st[1], 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule